// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of a vector register under a per-element mask, one element per clock. In compress mode it walks the source register from index 0 upward. Each element whose mask bit is set is written to the next free destination slot, so the selected elements end up packed at the bottom of the destination in their original order. In expand mode it does the reverse. Source elements are taken in order from index 0. Each one is placed at the position of the next set mask bit, and every other destination position is left as it was.

The unit sits next to a register file. It drives a source read address and receives the read data in the same cycle. It writes the destination through an address, data and write-enable port. A single-cycle `start` captures the operation, the vector length and the mask. `busy` covers the whole operation. A one-cycle `done` pulse marks the end, and `packLen` then shows the number of elements that were moved, which is the population count of the mask below the vector length.

Top module: `ccx_unit`

## Requirements
- R1: Mode encoding is `mode`=0 for compress and `mode`=1 for expand. Mask bit i (`mask[i]`) belongs to element i. In compress, the source element i with `mask[i]`=1 is written to the destination in order of increasing i.
- R2: In compress, destination writes go to consecutive addresses starting at 0. The write address never exceeds the source read address of the same cycle.
- R3: When `done` is high, `packLen` equals the number of set mask bits below the effective vector length. `packLen` holds that value while the unit is idle.
- R4: In expand, the k-th source element (index k, counting from 0) is written to the position of the k-th set mask bit. The source read address never exceeds the write address.
- R5: In expand, destination positions whose mask bit is 0 are not written and keep their previous contents.
- R6: The effective vector length is `vl` clamped to MAX_VL. Elements and mask bits at or above it are ignored, and no destination position at or above it is written in expand.
- R7: In compress, destination positions at or beyond the packed length are not written.
- R8: One element is processed per cycle. With `start` sampled at clock edge 0, `done` is high for exactly one cycle, after edge max(effective length,1)+1. `busy` is high from edge 1 through the `done` cycle, and no write happens while `busy` is low.
- R9: `start` is ignored while `busy` is high, including during the `done` cycle. Changes to `mode`, `vl` or `mask` after capture have no effect on the running operation.
- R10: After reset, `busy`, `done` and `wrEn` are 0 and `packLen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode | input | 1 | 0 = compress, 1 = expand |
| vl | input | LEN_W | Requested vector length (clamped to MAX_VL) |
| mask | input | MAX_VL | Per-element mask, bit i for element i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| packLen | output | LEN_W | Number of moved elements |
| rdAddr | output | IDX_W | Source read address |
| rdData | input | ELEM_W | Source read data (same cycle) |
| wrEn | output | 1 | Destination write enable |
| wrAddr | output | IDX_W | Destination write address |
| wrData | output | ELEM_W | Destination write data |

## Verification
A new `start` can land in the same cycle as the unit finishing its previous operation. It can also land while elements are still streaming. The bench provokes the first case by raising `start`, with a different mode and mask, in exactly the cycle where `done` is seen. It provokes the second by raising `start` in the middle of a run. In both cases it judges the outcome by the destination array, which must match the model of the original operation with no extra writes in the following cycles, and by `packLen` and `busy`, which must stay at the completed values and return to idle.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  typedef enum logic {
    MODE_COMPRESS = 1'b0,
    MODE_EXPAND   = 1'b1
  } ccxMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operation operands, clear counters
    logic step;  // process the element at the current index
  } ccxStrobe_t;
endpackage

// File: rtl/ccx_ctrl.sv
module ccx_ctrl
  import ccx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       vlZero,
  input  logic       isLast,
  output ccxStrobe_t strb,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ccxState_e;

  ccxState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        if (vlZero) begin
          stateNext = ST_FIN;
        end else begin
          strb.step = 1'b1;
          if (isLast) stateNext = ST_FIN;
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/ccx_datapath.sv
module ccx_datapath
  import ccx_pkg::*;
#(
  parameter int ELEM_W = 16,
  parameter int MAX_VL = 16,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int LEN_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccxStrobe_t        strb,
  input  ccxMode_e          mode,
  input  logic [LEN_W-1:0]  vl,
  input  logic [MAX_VL-1:0] mask,
  input  logic [ELEM_W-1:0] rdData,
  output logic [IDX_W-1:0]  rdAddr,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [ELEM_W-1:0] wrData,
  output logic [LEN_W-1:0]  packLen,
  output logic              vlZero,
  output logic              isLast
);
  localparam logic [LEN_W-1:0] VL_CAP = LEN_W'(MAX_VL);

  ccxMode_e          modeReg;
  logic [LEN_W-1:0]  vlReg;
  logic [MAX_VL-1:0] maskReg;
  logic [LEN_W-1:0]  idx;   // element index being examined
  logic [LEN_W-1:0]  ptr;   // running pack pointer (write in compress, read in expand)
  logic [LEN_W-1:0]  vlClamped;
  logic              curBit;

  assign vlClamped = (vl > VL_CAP) ? VL_CAP : vl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_COMPRESS;
      vlReg   <= '0;
      maskReg <= '0;
      idx     <= '0;
      ptr     <= '0;
    end else if (strb.load) begin
      modeReg <= mode;
      vlReg   <= vlClamped;
      maskReg <= mask;
      idx     <= '0;
      ptr     <= '0;
    end else if (strb.step) begin
      idx <= idx + 1'b1;
      if (curBit) ptr <= ptr + 1'b1;
    end
  end

  assign curBit = maskReg[idx[IDX_W-1:0]];
  assign vlZero = (vlReg == '0);
  assign isLast = (idx == vlReg - 1'b1);

  assign rdAddr  = (modeReg == MODE_EXPAND) ? ptr[IDX_W-1:0] : idx[IDX_W-1:0];
  assign wrAddr  = (modeReg == MODE_EXPAND) ? idx[IDX_W-1:0] : ptr[IDX_W-1:0];
  assign wrEn    = strb.step & curBit;
  assign wrData  = rdData;
  assign packLen = ptr;
endmodule

// File: rtl/ccx_unit.sv
module ccx_unit
  import ccx_pkg::*;
#(
  parameter int ELEM_W = 16,
  parameter int MAX_VL = 16,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int LEN_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              mode,
  input  logic [LEN_W-1:0]  vl,
  input  logic [MAX_VL-1:0] mask,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  packLen,
  output logic [IDX_W-1:0]  rdAddr,
  input  logic [ELEM_W-1:0] rdData,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [ELEM_W-1:0] wrData
);
  ccxStrobe_t strb;
  logic       vlZero;
  logic       isLast;

  ccx_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .vlZero (vlZero),
    .isLast (isLast),
    .strb   (strb),
    .busy   (busy),
    .done   (done)
  );

  ccx_datapath #(
    .ELEM_W (ELEM_W),
    .MAX_VL (MAX_VL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .mode    (ccxMode_e'(mode)),
    .vl      (vl),
    .mask    (mask),
    .rdData  (rdData),
    .rdAddr  (rdAddr),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .packLen (packLen),
    .vlZero  (vlZero),
    .isLast  (isLast)
  );
endmodule

// File: rtl/ccx_unit_chk.sv
module ccx_unit_chk #(
  parameter int MAX_VL = 16,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int LEN_W = $clog2(MAX_VL + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             mode,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] packLen,
  input logic [IDX_W-1:0] rdAddr,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrAddr
);
  logic opMode;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               opMode <= 1'b0;
    else if (start && !busy) opMode <= mode;
  end

  // R8: writes only during an operation
  p_write_needs_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  // R8: done is a single-cycle pulse that ends the operation
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R8: busy only falls right after done
  p_busy_ends_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R2: compress write pointer never overtakes the source index
  p_compress_no_overtake_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !opMode) |-> (wrAddr <= rdAddr));

  // R4: expand read pointer never overtakes the destination index
  p_expand_no_overtake_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opMode) |-> (rdAddr <= wrAddr));

  // R3: packed length holds while idle
  p_len_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(packLen));
endmodule

bind ccx_unit ccx_unit_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .mode    (mode),
  .busy    (busy),
  .done    (done),
  .packLen (packLen),
  .rdAddr  (rdAddr),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr)
);

// File: tb/ccx_unit_test.sv
`timescale 1ns/1ps
module ccx_unit_test;
  localparam int ELEM_W = 16;
  localparam int MAX_VL = 16;
  localparam int IDX_W  = 4;
  localparam int LEN_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              mode = 1'b0;
  logic [LEN_W-1:0]  vl = '0;
  logic [MAX_VL-1:0] mask = '0;
  logic              busy, done, wrEn;
  logic [LEN_W-1:0]  packLen;
  logic [IDX_W-1:0]  rdAddr, wrAddr;
  logic [ELEM_W-1:0] rdData, wrData;

  logic [ELEM_W-1:0] srcMem [MAX_VL];
  logic [ELEM_W-1:0] dstMem [MAX_VL];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  ccx_unit #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL)) uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .vl(vl), .mask(mask),
    .busy(busy), .done(done), .packLen(packLen), .rdAddr(rdAddr),
    .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign rdData = srcMem[rdAddr];
  always_ff @(posedge clk) if (wrEn) dstMem[wrAddr] <= wrData;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkDst(input string req, input logic [ELEM_W-1:0] exp [MAX_VL]);
    int bad = -1;
    checks++;
    for (int i = 0; i < MAX_VL; i++) if (bad < 0 && dstMem[i] !== exp[i]) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s dst[%0d]: actual %h expected %h", req, bad, dstMem[bad], exp[bad]);
    end
  endtask

  // midStart: 0 none, 1 start pulse mid-run, 2 start pulse in done cycle
  task automatic runOp(input string req, input logic m, input int vlIn,
                       input logic [MAX_VL-1:0] mk, input int midStart, input int seed);
    logic [ELEM_W-1:0] exp [MAX_VL];
    int effVl, cnt, n, expCyc;
    for (int i = 0; i < MAX_VL; i++) begin
      srcMem[i] = ELEM_W'(16'h5000 + seed * 32 + i);
      dstMem[i] = ELEM_W'(16'hD000 + seed * 32 + i);
      exp[i]    = dstMem[i];
    end
    effVl = (vlIn > MAX_VL) ? MAX_VL : vlIn;
    cnt = 0;
    for (int i = 0; i < effVl; i++) begin
      if (mk[i]) begin
        if (!m) exp[cnt] = srcMem[i];
        else    exp[i]   = srcMem[cnt];
        cnt++;
      end
    end
    expCyc = ((effVl == 0) ? 1 : effVl) + 1;

    @(negedge clk);
    mode = m; vl = LEN_W'(vlIn); mask = mk; start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0; mode = m; mask = mk;
      if (midStart == 1 && n == 2) begin
        start = 1'b1; mode = ~m; mask = ~mk;
      end
    end while (!done && n < 100);

    check("R8", {req, " cycles to done"}, n, expCyc);
    check("R8", {req, " busy with done"}, int'(busy), 1);
    check("R3", {req, " packLen at done"}, int'(packLen), cnt);
    checkDst(req, exp);

    if (midStart == 2) begin
      start = 1'b1; mode = ~m; mask = ~mk; vl = LEN_W'(MAX_VL);
    end
    @(negedge clk);
    start = 1'b0;
    check("R8", {req, " busy after done"}, int'(busy), 0);
    check("R9", {req, " done after pulse"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check("R9", {req, " still idle"}, int'(busy), 0);
    check("R3", {req, " packLen held"}, int'(packLen), cnt);
    checkDst("R9", exp);
  endtask

  task automatic testReset();
    check("R10", "busy", int'(busy), 0);
    check("R10", "done", int'(done), 0);
    check("R10", "wrEn", int'(wrEn), 0);
    check("R10", "packLen", int'(packLen), 0);
  endtask

  task automatic testCompress();
    runOp("R1 R2 R7 compress mixed", 1'b0, 16, 16'b1010_0110_0011_0101, 0, 1);
    runOp("R1 R2 compress all ones", 1'b0, 16, 16'hFFFF, 0, 2);
    runOp("R7 compress all zero", 1'b0, 16, 16'h0000, 0, 3);
    runOp("R7 compress top bit only", 1'b0, 16, 16'h8000, 0, 4);
  endtask

  task automatic testExpand();
    runOp("R4 R5 expand mixed", 1'b1, 16, 16'b1010_0110_0011_0101, 0, 5);
    runOp("R4 R5 expand alternating", 1'b1, 16, 16'h5555, 0, 6);
    runOp("R4 expand all ones", 1'b1, 16, 16'hFFFF, 0, 7);
  endtask

  task automatic testLength();
    runOp("R6 compress short vl", 1'b0, 5, 16'hFFF5, 0, 8);
    runOp("R6 expand short vl", 1'b1, 5, 16'hFFF5, 0, 9);
    runOp("R6 R8 vl zero", 1'b0, 0, 16'hFFFF, 0, 10);
    runOp("R6 vl clamped", 1'b1, 20, 16'h9C3A, 0, 11);
    runOp("R8 vl one", 1'b0, 1, 16'h0001, 0, 12);
  endtask

  task automatic testStartWhileBusy();
    runOp("R9 start mid-run compress", 1'b0, 12, 16'h0A5C, 1, 13);
    runOp("R9 start mid-run expand", 1'b1, 12, 16'h0A5C, 1, 14);
    runOp("R9 start in done cycle", 1'b0, 8, 16'h00B6, 2, 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAX_VL; i++) begin
      srcMem[i] = '0;
      dstMem[i] = '0;
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCompress();
    testExpand();
    testLength();
    testStartWhileBusy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule